// File: doc/BRIEF.md
# Zoned Tamper-Erased Backup Register File

This block is a bank of retention registers reached over a simple single-cycle register bus. Every request carries a secure/nonsecure attribute. Two programmable borders, held in one configuration word, split the bank by index into three protection zones. The bottom zone is private to secure accesses. The middle zone is readable by anyone but writable only by secure accesses. The top zone is open to all. A request that breaks the policy is answered with zero data and a one-cycle error flag, and it changes nothing.

A tamper input erases the whole bank. Any write that arrives while the erase is pending is dropped. The lowest `KEY_REGS` registers are also concatenated onto a side-band key bus toward a crypto engine, and they never pass through the read path to reach it. The key bus is only live when every key register lies in the secure-only zone and no erase is pending.

Top module: `zbr_bank`

## Requirements
- R1: Register n is at byte address 4*n. A request presented in cycle t is answered in cycle t+1 with `rsp_valid` high. A byte address whose two low bits are not zero is rejected with `rsp_err`, reads back zero and writes nothing.
- R2: A register whose index is below the lower border can be read and written only by secure requests.
- R3: A register whose index is at or above the lower border and below the upper border can be read by any request, but can be written only by a secure request.
- R4: A register whose index is at or above the upper border can be read and written by any request.
- R5: The configuration word is at byte address 4*NREG. It holds the lower border in bits [BW-1:0] and the upper border in bits starting at DW/2, with BW = clog2(NREG+1). Any request may read it. After reset it holds LO_RST and HI_RST (48 and 96 by default).
- R6: A configuration write is accepted only when it is secure, the new lower border is no greater than the new upper border, and the upper border is at most NREG. Any other configuration write leaves both borders unchanged and raises `rsp_err`.
- R7: A denied read returns zero data, and a denied write leaves storage unchanged. Either case raises `rsp_err` for exactly the response cycle. A word address above NREG always errs and reads zero.
- R8: If `tamper_i` is high at clock edge k, every bank register is zero after edge k+1. Any write presented in the cycle between those two edges is dropped without error. The borders are not affected.
- R9: `key_data` equals registers KEY_REGS-1..0 concatenated, with register 0 in the least significant word. It is valid only while the lower border is at least KEY_REGS and no erase is pending. While it is not valid, `key_valid` is low and `key_data` is zero.
- R10: A synchronous reset clears every bank register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request carries the secure attribute |
| req_addr | input | clog2(NREG+2)+2 | Byte address |
| req_wdata | input | DW | Write data |
| tamper_i | input | 1 | Tamper event, erase request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused or ill-formed |
| rsp_rdata | output | DW | Read data, zero for writes and refusals |
| key_valid | output | 1 | Key bus content is usable |
| key_data | output | KEY_REGS*DW | Side-band key bus |

## Verification
The bench builds the bank with NREG=16, DW=16, KEY_REGS=4, LO_RST=6 and HI_RST=12. With this size it can try every border pair from 0 to 17, which includes reversed pairs and pairs beyond the bank. For each pair it first attempts a nonsecure configuration write and then a secure one. It then writes and reads every register from both sides, so every zone edge, empty zones, a bank that is fully secure and a bank that is fully open are all reached. Because KEY_REGS is 4, the key bus moves between live and dead as the lower border crosses 4. An erase is then placed so that it collides with writes on both sides of the pending cycle.

// File: rtl/zbr_pkg.sv
package zbr_pkg;

  // Protection class of one register index
  typedef enum logic [1:0] {
    ZONE_PRIVATE = 2'd0,  // secure read, secure write
    ZONE_GUARDED = 2'd1,  // any read, secure write
    ZONE_PUBLIC  = 2'd2   // any read, any write
  } zone_e;

endpackage

// File: rtl/zbr_zone_check.sv
module zbr_zone_check
  import zbr_pkg::*;
#(
  parameter int IW = 7,
  parameter int BW = 8
) (
  input  logic [IW-1:0] idx,
  input  logic [BW-1:0] lo,
  input  logic [BW-1:0] hi,
  input  logic          secure,
  input  logic          write,
  output logic          allow
);

  logic [BW-1:0] idx_w;
  zone_e         zone;

  assign idx_w = BW'(idx);

  always_comb begin
    if (idx_w < lo)      zone = ZONE_PRIVATE;
    else if (idx_w < hi) zone = ZONE_GUARDED;
    else                 zone = ZONE_PUBLIC;
  end

  always_comb begin
    unique case (zone)
      ZONE_PRIVATE: allow = secure;
      ZONE_GUARDED: allow = secure || !write;
      default:      allow = 1'b1;
    endcase
  end

endmodule

// File: rtl/zbr_border_regs.sv
module zbr_border_regs #(
  parameter int NREG   = 128,
  parameter int BW     = 8,
  parameter int LO_RST = 48,
  parameter int HI_RST = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          secure,
  input  logic [BW-1:0] cand_lo,
  input  logic [BW-1:0] cand_hi,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          reject_o
);

  logic [BW-1:0] lo_q, hi_q;
  logic          ok;

  assign ok       = secure && (cand_lo <= cand_hi) && (cand_hi <= BW'(NREG));
  assign reject_o = wr_en && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= BW'(LO_RST);
      hi_q <= BW'(HI_RST);
    end else if (wr_en && ok) begin
      lo_q <= cand_lo;
      hi_q <= cand_hi;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R6: borders always stay ordered and inside the bank
  a_r6_border_order: assert property (@(posedge clk) disable iff (rst)
    (lo_q <= hi_q) && (hi_q <= BW'(NREG)));

  // R6: a refused configuration write moves neither border
  a_r6_reject_holds: assert property (@(posedge clk) disable iff (rst)
    reject_o |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/zbr_store.sv
module zbr_store #(
  parameter int NREG     = 128,
  parameter int DW       = 32,
  parameter int IW       = 7,
  parameter int KEY_REGS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wipe,
  input  logic                   we,
  input  logic [IW-1:0]          idx,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [KEY_REGS*DW-1:0] key_raw
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

  for (genvar g = 0; g < KEY_REGS; g++) begin : g_key
    assign key_raw[g*DW +: DW] = mem[g];
  end

  // R8: an erase leaves the bank empty at both ends
  a_r8_wipe_clears: assert property (@(posedge clk) disable iff (rst)
    wipe |=> ((mem[0] == '0) && (mem[NREG-1] == '0)));

endmodule

// File: rtl/zbr_bank.sv
module zbr_bank #(
  parameter int NREG     = 128,
  parameter int DW       = 32,
  parameter int KEY_REGS = 8,
  parameter int LO_RST   = 48,
  parameter int HI_RST   = 96,
  localparam int WW      = $clog2(NREG + 2),
  localparam int AW      = WW + 2,
  localparam int KW      = KEY_REGS * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_secure,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          tamper_i,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          key_valid,
  output logic [KW-1:0] key_data
);

  localparam int IW = $clog2(NREG);
  localparam int BW = $clog2(NREG + 1);
  localparam int HP = DW / 2;

  // ---------------- address decode ----------------
  logic [WW-1:0] word;
  logic          misaligned, is_reg, is_cfg, bad_addr;
  logic [IW-1:0] idx;

  assign word       = req_addr[AW-1:2];
  assign misaligned = |req_addr[1:0];
  assign is_reg     = !misaligned && (word < WW'(NREG));
  assign is_cfg     = !misaligned && (word == WW'(NREG));
  assign bad_addr   = !is_reg && !is_cfg;
  assign idx        = word[IW-1:0];

  // ---------------- tamper staging ----------------
  logic tamper_q;
  always_ff @(posedge clk) begin
    if (rst) tamper_q <= 1'b0;
    else     tamper_q <= tamper_i;
  end

  logic write_drop;
  assign write_drop = req_write && tamper_q;

  // ---------------- borders ----------------
  logic [BW-1:0] lo, hi;
  logic          cfg_we, cfg_reject;

  assign cfg_we = req_valid && req_write && is_cfg && !tamper_q;

  zbr_border_regs #(
    .NREG(NREG), .BW(BW), .LO_RST(LO_RST), .HI_RST(HI_RST)
  ) border_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .secure   (req_secure),
    .cand_lo  (req_wdata[BW-1:0]),
    .cand_hi  (req_wdata[HP +: BW]),
    .lo_o     (lo),
    .hi_o     (hi),
    .reject_o (cfg_reject)
  );

  // ---------------- policy ----------------
  logic allow;

  zbr_zone_check #(.IW(IW), .BW(BW)) zone_i (
    .idx    (idx),
    .lo     (lo),
    .hi     (hi),
    .secure (req_secure),
    .write  (req_write),
    .allow  (allow)
  );

  // ---------------- storage ----------------
  logic          reg_we;
  logic [DW-1:0] rd_word;
  logic [KW-1:0] key_raw;

  assign reg_we = req_valid && req_write && is_reg && allow && !tamper_q;

  zbr_store #(
    .NREG(NREG), .DW(DW), .IW(IW), .KEY_REGS(KEY_REGS)
  ) store_i (
    .clk     (clk),
    .rst     (rst),
    .wipe    (tamper_q),
    .we      (reg_we),
    .idx     (idx),
    .wdata   (req_wdata),
    .rdata   (rd_word),
    .key_raw (key_raw)
  );

  // ---------------- response ----------------
  logic [DW-1:0] cfg_word, rd_next;
  logic          err_next;

  always_comb begin
    cfg_word            = '0;
    cfg_word[BW-1:0]    = lo;
    cfg_word[HP +: BW]  = hi;
  end

  always_comb begin
    rd_next = '0;
    if (req_valid && !req_write) begin
      if (is_reg && allow) rd_next = rd_word;
      else if (is_cfg)     rd_next = cfg_word;
    end
  end

  assign err_next = req_valid &&
                    (bad_addr || (is_reg && !allow && !write_drop) || cfg_reject);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_next;
      rsp_rdata <= rd_next;
    end
  end

  // ---------------- key bus ----------------
  assign key_valid = (lo >= BW'(KEY_REGS)) && !tamper_q;
  assign key_data  = key_valid ? key_raw : '0;

  // R7: an error only ever accompanies a response
  a_r7_err_has_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);

  // R7: a refused read hands back zero
  a_r7_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err && !$past(req_write)) |-> (rsp_rdata == '0));

  // R9: the key bus is dead in the cycle after a sampled tamper
  a_r9_key_off_on_tamper: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tamper_i)) |-> !key_valid);

endmodule

// File: tb/zbr_bank_tb_top.sv
module zbr_bank_tb_top;

  localparam int NREG = 16;
  localparam int DW   = 16;
  localparam int KR   = 4;
  localparam int LO0  = 6;
  localparam int HI0  = 12;
  localparam int AW   = $clog2(NREG + 2) + 2;
  localparam int KW   = KR * DW;
  localparam int HP   = DW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          tamper_i = 1'b0;
  logic          rsp_valid, rsp_err, key_valid;
  logic [DW-1:0] rsp_rdata;
  logic [KW-1:0] key_data;

  always #4 clk = ~clk;  // 125 MHz

  zbr_bank #(
    .NREG(NREG), .DW(DW), .KEY_REGS(KR), .LO_RST(LO0), .HI_RST(HI0)
  ) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .req_addr(req_addr), .req_wdata(req_wdata), .tamper_i(tamper_i),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .key_valid(key_valid), .key_data(key_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] mdl [NREG];
  int lo_m, hi_m;

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit allow_m(int i, bit s, bit w);
    if (i < lo_m) return s;
    if (i < hi_m) return w ? s : 1'b1;
    return 1'b1;
  endfunction

  function automatic string zone_tag(int i);
    if (i < lo_m) return "R2";
    if (i < hi_m) return "R3";
    return "R4";
  endfunction

  function automatic logic [DW-1:0] cfg_of(int lo, int hi);
    logic [DW-1:0] c;
    c = DW'(lo) | (DW'(hi) << HP);
    return c;
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic op(input bit wr, input bit sec, input int addr,
                    input logic [DW-1:0] wd,
                    output logic [DW-1:0] rd, output logic er, output logic vl);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_addr   = AW'(addr);
    req_wdata  = wd;
    @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
    vl = rsp_valid;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic key_check(input bool_pend);
    logic [KW-1:0] k;
    bit v;
    v = (lo_m >= KR) && !bool_pend;
    k = '0;
    if (v) for (int g = 0; g < KR; g++) k[g*DW +: DW] = mdl[g];
    chk_eq("R9", "key valid", 64'(key_valid), 64'(v));
    chk_eq("R9", "key data", 64'(key_data), 64'(k));
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic er, vl;
    logic [DW-1:0] wd;
    bit al, cfg_ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    lo_m = LO0;
    hi_m = HI0;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;

    // reset state
    op(0, 0, NREG * 4, '0, rd, er, vl);
    chk_eq("R1", "response valid", 64'(vl), 64'd1);
    chk_eq("R5", "reset borders", 64'(rd), 64'(cfg_of(LO0, HI0)));
    chk_eq("R5", "config read err", 64'(er), 64'd0);
    for (int i = 0; i < NREG; i++) begin
      op(0, 1, i * 4, '0, rd, er, vl);
      chk_eq("R10", "reset content", 64'(rd), 64'd0);
    end
    key_check(0);

    // ill-formed addresses
    op(1, 1, NREG * 4 + 4, 16'h5a5a, rd, er, vl);
    chk_eq("R7", "out-of-range write err", 64'(er), 64'd1);
    op(0, 1, NREG * 4 + 4, '0, rd, er, vl);
    chk_eq("R7", "out-of-range read err", 64'(er), 64'd1);
    chk_eq("R7", "out-of-range read data", 64'(rd), 64'd0);
    op(1, 1, 3 * 4 + 1, 16'h1234, rd, er, vl);
    chk_eq("R1", "misaligned write err", 64'(er), 64'd1);
    op(0, 1, 3 * 4, '0, rd, er, vl);
    chk_eq("R1", "misaligned write had no effect", 64'(rd), 64'd0);
    op(0, 1, 3 * 4 + 2, '0, rd, er, vl);
    chk_eq("R1", "misaligned read err", 64'(er), 64'd1);

    // sweep every border pair
    for (int lo = 0; lo <= NREG + 1; lo++) begin
      for (int hi = 0; hi <= NREG + 1; hi++) begin
        op(1, 0, NREG * 4, cfg_of(lo, hi), rd, er, vl);
        chk_eq("R6", "nonsecure border write err", 64'(er), 64'd1);
        cfg_ok = (lo <= hi) && (hi <= NREG);
        op(1, 1, NREG * 4, cfg_of(lo, hi), rd, er, vl);
        chk_eq("R6", "secure border write err", 64'(er), 64'(!cfg_ok));
        if (cfg_ok) begin
          lo_m = lo;
          hi_m = hi;
        end
        op(0, 0, NREG * 4, '0, rd, er, vl);
        chk_eq("R5", "border readback", 64'(rd), 64'(cfg_of(lo_m, hi_m)));

        for (int i = 0; i < NREG; i++) begin
          for (int s = 0; s < 2; s++) begin
            al = allow_m(i, s[0], 1'b1);
            wd = DW'(i * 97 + lo * 13 + hi * 7 + s * 3 + 1);
            op(1, s[0], i * 4, wd, rd, er, vl);
            chk_eq(zone_tag(i), "write err", 64'(er), 64'(!al));
            if (al) mdl[i] = wd;
          end
        end
        for (int i = 0; i < NREG; i++) begin
          for (int s = 0; s < 2; s++) begin
            al = allow_m(i, s[0], 1'b0);
            op(0, s[0], i * 4, '0, rd, er, vl);
            chk_eq(zone_tag(i), "read err", 64'(er), 64'(!al));
            chk_eq(zone_tag(i), "read data", 64'(rd), al ? 64'(mdl[i]) : 64'd0);
          end
        end
        key_check(0);
      end
    end

    // tamper erase: write in the sampling cycle lands, write in pending cycle drops
    for (int i = 0; i < NREG; i++) begin
      wd = DW'(16'hc000 + i);
      op(1, 1, i * 4, wd, rd, er, vl);
      mdl[i] = wd;
    end
    key_check(0);
    tamper_i = 1'b1;
    op(1, 1, 1 * 4, 16'hbeef, rd, er, vl);
    tamper_i = 1'b0;
    mdl[1] = 16'hbeef;
    chk_eq("R8", "write before erase accepted", 64'(er), 64'd0);
    key_check(1);
    op(1, 1, 2 * 4, 16'hfeed, rd, er, vl);
    chk_eq("R8", "pending-cycle write no err", 64'(er), 64'd0);
    chk_eq("R8", "pending-cycle write response", 64'(vl), 64'd1);
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    for (int i = 0; i < NREG; i++) begin
      op(0, 1, i * 4, '0, rd, er, vl);
      chk_eq("R8", "erased content", 64'(rd), 64'd0);
    end
    op(0, 1, NREG * 4, '0, rd, er, vl);
    chk_eq("R8", "borders survive erase", 64'(rd), 64'(cfg_of(lo_m, hi_m)));
    key_check(0);

    finished = 1;
    report();
    $finish;
  end

endmodule